// File: doc/BRIEF.md
# Asynchronous Bus Region Decoder and Transfer Acknowledge

This block is the glue between a 16-bit asynchronous-bus processor and its memories and peripherals. Every clock it samples the 24-bit address, the address strobe, the two byte-lane data strobes, the read/write line and a boot overlay flag, and from them drives the chip selects for four RAM banks, a ROM and three peripheral windows, per-lane output and write enables for 16-bit wide memories, and the two cycle-termination signals. Regular memory and peripheral regions end a cycle with the data-transfer acknowledge; the slow serial window, built from older 8-bit synchronous peripherals, gets the valid-peripheral-address signal instead so the processor runs its synchronous peripheral cycle.

RAM sits at the bottom of the address space, but the processor fetches its reset vectors from address zero, so while the boot flag is asserted every access goes to the ROM and all RAM banks stay off. All outputs are active low and registered, so each follows the sampled inputs one clock later and all of them return inactive one clock after the address strobe is released.

Top module: `bus_glue_decoder`

## Requirements
- R1: With the address strobe low and the boot flag high, an address with A23:A22 = 00 drives exactly the RAM bank select numbered by A21:A20 low (ram_cs_no[0] for bank 0 up to ram_cs_no[3] for bank 3).
- R2: While the boot flag is low, all four RAM bank selects stay high for every address.
- R3: With the address strobe low, the ROM select is low when A23:A20 = 0101; A19:A0 are not decoded, so $500000 and $5F1234 both hit the ROM.
- R4: While the boot flag is low and the address strobe low, the ROM select is low for every address and every other chip select stays high.
- R5: With the address strobe low and the boot flag high, A23:A16 = $FE selects the serial window, $FD the video window and $FB the microcontroller window.
- R6: Lane index 1 of the enables belongs to the upper strobe (D15-D8), index 0 to the lower strobe (D7-D0); a lane's output enable is low only when the address strobe and that lane's strobe are low and read/write is high, its write enable only when both strobes are low and read/write is low.
- R7: The acknowledge output is low whenever a RAM bank, ROM, video or microcontroller select is low.
- R8: An access to the serial window drives the valid-peripheral-address output low and leaves the acknowledge high.
- R9: An unmapped address (for example $400000, $800000, $FC0000, $FF0000) drives no select, no acknowledge and no valid-peripheral-address.
- R10: Every output reflects the inputs sampled at the previous rising clock edge; one clock after the address strobe goes high all outputs are high.
- R11: During reset all outputs are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Processor address A23:A0 |
| as_ni | input | 1 | Address strobe, active low |
| uds_ni | input | 1 | Upper data strobe (D15-D8), active low |
| lds_ni | input | 1 | Lower data strobe (D7-D0), active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| boot_ni | input | 1 | Boot overlay flag, active low |
| ram_cs_no | output | 4 | RAM bank selects, active low |
| rom_cs_no | output | 1 | ROM select, active low |
| ser_cs_no | output | 1 | Serial window select, active low |
| vid_cs_no | output | 1 | Video window select, active low |
| mcu_cs_no | output | 1 | Microcontroller window select, active low |
| oe_no | output | 2 | Per-lane output enables, active low, [1] upper |
| we_no | output | 2 | Per-lane write enables, active low, [1] upper |
| dtack_no | output | 1 | Data-transfer acknowledge, active low |
| vpa_no | output | 1 | Valid peripheral address, active low |

## Verification
A wrong decode shows at the ports in the clock after the offending address is sampled: two selects low at once, a select with no matching termination, or a serial access that acknowledges and so skips the slow peripheral cycle, which on a real bus hangs or corrupts the transfer. A stuck registered output shows as a select or acknowledge still low one clock after the address strobe rises, which the processor would read as the next cycle ending early. Sweeping addresses at both ends of every region and in the gaps, under each strobe and direction and with the boot flag in both states, exposes each of these within one cycle of the stimulus.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  localparam int unsigned ADDR_W     = 24;
  localparam int unsigned RAM_BANKS  = 4;
  localparam int unsigned BANK_W     = $clog2(RAM_BANKS);
  localparam int unsigned BANK_OFF_W = 20;
  localparam int unsigned LANES      = 2;
  localparam int unsigned TAG_W      = 8;

  typedef struct packed {
    logic [RAM_BANKS-1:0] ram;
    logic                 rom;
    logic                 ser;
    logic                 vid;
    logic                 mcu;
  } region_sel_t;
endpackage

// File: rtl/bus_region_dec.sv
module bus_region_dec
  import bus_glue_pkg::*;
#(
  parameter logic [3:0]       ROM_TAG  = 4'h5,
  parameter logic [TAG_W-1:0] SER_TAG  = 8'hFE,
  parameter logic [TAG_W-1:0] VID_TAG  = 8'hFD,
  parameter logic [TAG_W-1:0] MCU_TAG  = 8'hFB
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic             as_i,
  input  logic             boot_i,
  output region_sel_t      sel_o
);
  localparam int unsigned RAM_HI_W = ADDR_W - BANK_OFF_W - BANK_W;

  logic              ram_hit;
  logic [BANK_W-1:0] bank_idx;
  logic              norm;

  assign norm     = as_i & ~boot_i;
  assign ram_hit  = (tag_i[TAG_W-1 -: RAM_HI_W] == '0);
  assign bank_idx = tag_i[TAG_W-1-RAM_HI_W -: BANK_W];

  for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
    assign sel_o.ram[b] = norm & ram_hit & (bank_idx == BANK_W'(b));
  end

  // boot overlay forces ROM everywhere
  assign sel_o.rom = as_i & (boot_i | (tag_i[TAG_W-1 -: 4] == ROM_TAG));
  assign sel_o.ser = norm & (tag_i == SER_TAG);
  assign sel_o.vid = norm & (tag_i == VID_TAG);
  assign sel_o.mcu = norm & (tag_i == MCU_TAG);
endmodule

// File: rtl/bus_lane_ctl.sv
module bus_lane_ctl
  import bus_glue_pkg::*;
(
  input  logic             as_i,
  input  logic [LANES-1:0] strb_i,
  input  logic             rw_i,
  output logic [LANES-1:0] oe_o,
  output logic [LANES-1:0] we_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign oe_o[l] = as_i & strb_i[l] &  rw_i;
    assign we_o[l] = as_i & strb_i[l] & ~rw_i;
  end
endmodule

// File: rtl/bus_ack_gen.sv
module bus_ack_gen
  import bus_glue_pkg::*;
(
  input  region_sel_t sel_i,
  output logic        dtack_o,
  output logic        vpa_o
);
  assign dtack_o = (|sel_i.ram) | sel_i.rom | sel_i.vid | sel_i.mcu;
  assign vpa_o   = sel_i.ser;
endmodule

// File: rtl/bus_glue_decoder.sv
module bus_glue_decoder
  import bus_glue_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 as_ni,
  input  logic                 uds_ni,
  input  logic                 lds_ni,
  input  logic                 rw_i,
  input  logic                 boot_ni,
  output logic [RAM_BANKS-1:0] ram_cs_no,
  output logic                 rom_cs_no,
  output logic                 ser_cs_no,
  output logic                 vid_cs_no,
  output logic                 mcu_cs_no,
  output logic [LANES-1:0]     oe_no,
  output logic [LANES-1:0]     we_no,
  output logic                 dtack_no,
  output logic                 vpa_no
);
  region_sel_t      sel_d, sel_q;
  logic [LANES-1:0] oe_d, we_d, oe_q, we_q;
  logic             dtack_d, vpa_d, dtack_q, vpa_q;
  logic             unused_low;

  assign unused_low = ^addr_i[ADDR_W-TAG_W-1:0];

  bus_region_dec u_dec (
    .tag_i  (addr_i[ADDR_W-1 -: TAG_W]),
    .as_i   (~as_ni),
    .boot_i (~boot_ni),
    .sel_o  (sel_d)
  );

  bus_lane_ctl u_lane (
    .as_i   (~as_ni),
    .strb_i ({~uds_ni, ~lds_ni}),
    .rw_i   (rw_i),
    .oe_o   (oe_d),
    .we_o   (we_d)
  );

  bus_ack_gen u_ack (
    .sel_i   (sel_d),
    .dtack_o (dtack_d),
    .vpa_o   (vpa_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      oe_q    <= '0;
      we_q    <= '0;
      dtack_q <= 1'b0;
      vpa_q   <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      dtack_q <= dtack_d;
      vpa_q   <= vpa_d;
    end
  end

  assign ram_cs_no = ~sel_q.ram;
  assign rom_cs_no = ~sel_q.rom;
  assign ser_cs_no = ~sel_q.ser;
  assign vid_cs_no = ~sel_q.vid;
  assign mcu_cs_no = ~sel_q.mcu;
  assign oe_no     = ~oe_q;
  assign we_no     = ~we_q;
  assign dtack_no  = ~dtack_q;
  assign vpa_no    = ~vpa_q;

  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~ram_cs_no, ~rom_cs_no, ~ser_cs_no, ~vid_cs_no, ~mcu_cs_no}) <= 1); // R1
  AST_BOOT_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_ni |=> (&ram_cs_no)); // R2
  AST_BOOT_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_ni && !as_ni) |=> !rom_cs_no); // R4
  AST_SER_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_cs_no |-> (dtack_no && !vpa_no)); // R8
  AST_ACK_HAS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no |-> !((&ram_cs_no) && rom_cs_no && vid_cs_no && mcu_cs_no)); // R7
  AST_LANE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~oe_no) & (~we_no)) == '0); // R6
  AST_AS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> ((&ram_cs_no) && rom_cs_no && ser_cs_no && vid_cs_no && mcu_cs_no
               && (&oe_no) && (&we_no) && dtack_no && vpa_no)); // R10
endmodule

// File: tb/bus_glue_decoder_bench.sv
module bus_glue_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1, boot_n = 1'b1;
  logic [3:0]  ram_cs_n;
  logic        rom_cs_n, ser_cs_n, vid_cs_n, mcu_cs_n, dtack_n, vpa_n;
  logic [1:0]  oe_n, we_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  bus_glue_decoder u_bus_glue_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .as_ni(as_n), .uds_ni(uds_n),
    .lds_ni(lds_n), .rw_i(rw), .boot_ni(boot_n), .ram_cs_no(ram_cs_n),
    .rom_cs_no(rom_cs_n), .ser_cs_no(ser_cs_n), .vid_cs_no(vid_cs_n),
    .mcu_cs_no(mcu_cs_n), .oe_no(oe_n), .we_no(we_n), .dtack_no(dtack_n),
    .vpa_no(vpa_n)
  );

  function automatic logic [13:0] outs();
    return {ram_cs_n, rom_cs_n, ser_cs_n, vid_cs_n, mcu_cs_n, oe_n, we_n, dtack_n, vpa_n};
  endfunction

  function automatic logic [13:0] model(logic [23:0] a, logic asn, logic un,
                                        logic ln, logic r, logic bn);
    logic as_a, boot, rom, ser, vid, mcu, dt;
    logic [3:0] ram;
    logic [1:0] oe, we;
    as_a = ~asn;
    boot = ~bn;
    for (int i = 0; i < 4; i++)
      ram[i] = as_a && !boot && a[23:22] == 2'b00 && a[21:20] == i[1:0];
    rom = as_a && (boot || a[23:20] == 4'h5);
    ser = as_a && !boot && a[23:16] == 8'hFE;
    vid = as_a && !boot && a[23:16] == 8'hFD;
    mcu = as_a && !boot && a[23:16] == 8'hFB;
    oe  = {as_a && !un && r,  as_a && !ln && r};
    we  = {as_a && !un && !r, as_a && !ln && !r};
    dt  = (|ram) || rom || vid || mcu;
    return ~{ram, rom, ser, vid, mcu, oe, we, dt, ser};
  endfunction

  task automatic drive(logic [23:0] a, logic asn, logic un, logic ln,
                       logic r, logic bn, string tag);
    @(negedge clk);
    addr = a; as_n = asn; uds_n = un; lds_n = ln; rw = r; boot_n = bn;
    exp_q.push_back(model(a, asn, un, ln, r, bn));
    tag_q.push_back(tag);
  endtask

  // monitor: compare one cycle after each drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [13:0] e, act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = outs();
        n_tests++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s act=%b exp=%b addr=%h", t, act, e, addr);
        end
        n_tests++;
        if ($countones(~act[13:6]) > 1) begin
          n_fail++;
          $display("FAIL R1 multiple selects act=%b exp=at most one", act[13:6]);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog act=%0d exp<=100000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] addrs[16];
    string       tags[16];
    addrs = '{24'h000010, 24'h1ABCDE, 24'h200000, 24'h3FFFFE,
              24'h500000, 24'h50FFFE, 24'h5F1234,
              24'hFE0001, 24'hFD8000, 24'hFB0010,
              24'h400000, 24'h600000, 24'hFF0000, 24'hFC0000, 24'h800000, 24'hFA0000};
    tags  = '{"R1", "R1", "R1", "R1", "R3", "R3", "R3",
              "R8", "R5", "R5", "R9", "R9", "R9", "R9", "R9", "R9"};

    repeat (3) @(posedge clk);
    #2;
    n_tests++; // R11 reset state
    if (outs() !== 14'h3FFF) begin
      n_fail++;
      $display("FAIL R11 act=%b exp=%b", outs(), 14'h3FFF);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3 R5 R6 R7 R8 R9: sweep regions, directions, lane strobes
    for (int i = 0; i < 16; i++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 3; s++) begin
          logic un, ln;
          un = (s == 2);
          ln = (s == 1);
          drive(addrs[i], 1'b0, un, ln, r[0], 1'b1, tags[i]);
        end

    // R2 R4: boot overlay across all addresses
    for (int i = 0; i < 16; i++) begin
      drive(addrs[i], 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
      drive(addrs[i], 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    end

    // R10: access then strobe release, outputs clear next cycle
    for (int i = 0; i < 16; i++) begin
      drive(addrs[i], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
      drive(addrs[i], 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
    end
    drive(24'h500000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10");

    // R7 explicit: video acknowledges, serial does not
    drive(24'hFDFFFE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
    drive(24'hFEFFFE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    drive(24'h000000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R10");

    repeat (3) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule